// File: doc/BRIEF.md
# Wavefront Memory Credit Tracker

This block decides, one cycle at a time, whether a vector memory instruction from one of several wavefronts may issue. It keeps one pool of coalescer tokens that all wavefronts share. For every wavefront it also keeps two counters: outstanding global reads and outstanding global writes. An instruction is granted only when the pool still holds a token and the sum of its wavefront's two counters is under a configured ceiling.

When an instruction is granted, one token leaves the pool and the wavefront's counters go up according to the instruction kind. An instruction whose lanes are all inactive sends no request to memory, so its token goes straight back to the pool in the same cycle. Completions bring the counters back down using the same kind rules. The coalescer returns tokens on its own input. Two sticky flags report misuse: a return that would overfill the pool, and a completion that finds its counter already at zero.

Top module: `wf_mem_credit`

## Requirements
- R1: After reset the pool holds TOKEN_MAX tokens, every read and write counter is zero, and both error flags are low.
- R2: `iss_grant` is low whenever the pool is empty or the requesting wavefront's read count plus write count is at least MAX_OUT.
- R3: `iss_grant` is high, in the same cycle, whenever `iss_req` is high, the pool holds at least one token and the wavefront's combined count is below MAX_OUT.
- R4: A granted instruction with at least one active lane lowers the pool by one token at the next clock edge.
- R5: A granted instruction with `iss_idle` high (all lanes inactive) leaves the pool level unchanged.
- R6: A grant raises the wavefront's counters by kind code: load (0) raises reads, store (1) raises writes, atomic (2) and memory sync (3) raise both.
- R7: A completion lowers the wavefront's counters under the same kind code rules as R6.
- R8: A token return and a token acquire in the same cycle are both applied to the pool.
- R9: A return that would take the pool above TOKEN_MAX sets `err_pool_ovf`, which stays set until reset, and the pool is held at TOKEN_MAX.
- R10: A completion that would take a counter below zero sets `err_underflow`, which stays set until reset, and the counter stays at zero.
- R11: An issue and a completion of the same kind on the same wavefront in the same cycle leave that counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_req | input | 1 | An instruction asks to issue |
| iss_wf | input | WFW | Wavefront of the issuing instruction |
| iss_kind | input | 2 | Kind code: 0 load, 1 store, 2 atomic, 3 memory sync |
| iss_idle | input | 1 | All lanes of the issuing instruction are inactive |
| iss_grant | output | 1 | Issue allowed in this cycle |
| cmp_valid | input | 1 | An instruction completes |
| cmp_wf | input | WFW | Wavefront of the completing instruction |
| cmp_kind | input | 2 | Kind code of the completing instruction |
| tok_ret | input | PW | Tokens returned by the coalescer this cycle |
| pool_level | output | PW | Tokens currently held in the pool |
| rd_cnt | output | NUM_WF*CW | Outstanding read counters, wavefront w at bits [w*CW +: CW] |
| wr_cnt | output | NUM_WF*CW | Outstanding write counters, same packing |
| err_pool_ovf | output | 1 | Sticky pool overfill flag |
| err_underflow | output | 1 | Sticky counter underflow flag |

## Verification
The assertions check on every cycle that a grant never happens without a request, a token or room under the ceiling, that the pool stays within its range, that idle counters do not move and that both error flags stay set once raised. Only the bench's scenarios can show the exact arithmetic: one token per active grant, no net change for an all-idle grant, a return and an acquire applied together, and the per-kind charging and discharging of the read and write counters, including an issue and a completion in the same cycle on one wavefront.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_ATOMIC = 2'd2,
    OP_SYNC   = 2'd3
  } op_kind_e;

  // Every kind except a plain store occupies the read side.
  function automatic logic uses_read(input op_kind_e k);
    return k != OP_STORE;
  endfunction

  // Every kind except a plain load occupies the write side.
  function automatic logic uses_write(input op_kind_e k);
    return k != OP_LOAD;
  endfunction
endpackage

// File: rtl/wmc_token_pool.sv
module wmc_token_pool #(
  parameter int TOKEN_MAX = 8,
  parameter int PW        = $clog2(TOKEN_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acquire,
  input  logic [PW-1:0] give_back,
  output logic [PW-1:0] level,
  output logic          ovf_err
);
  localparam logic [PW:0] CAP = (PW+1)'(TOKEN_MAX);

  logic [PW:0]   sum;
  logic          ovf_now;
  logic          pool_en;
  logic [PW-1:0] level_nxt;
  logic          err_nxt;

  always_comb begin
    sum       = {1'b0, level} + {1'b0, give_back} - {{PW{1'b0}}, acquire};
    ovf_now   = sum > CAP;
    level_nxt = ovf_now ? CAP[PW-1:0] : sum[PW-1:0];
    pool_en   = acquire | (give_back != '0);
    err_nxt   = ovf_err | ovf_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= CAP[PW-1:0];
      ovf_err <= 1'b0;
    end else if (pool_en) begin
      level   <= level_nxt;
      ovf_err <= err_nxt;
    end
  end

  assert_pool_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, level} <= CAP);
  assert_acquire_funded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acquire |-> level != '0);
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
endmodule

// File: rtl/wmc_dir_counter.sv
module wmc_dir_counter #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          underflow
);
  logic          cnt_en;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    underflow = dec & ~inc & (cnt == '0);
    cnt_en    = inc ^ dec;
    cnt_nxt   = cnt;
    if (inc && !dec)
      cnt_nxt = cnt + 1'b1;
    else if (dec && !inc && cnt != '0)
      cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (cnt_en)
      cnt <= cnt_nxt;
  end

  assert_uf_holds_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> cnt == '0);
  assert_quiet_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec) |=> $stable(cnt));
endmodule

// File: rtl/wf_mem_credit.sv
module wf_mem_credit #(
  parameter int NUM_WF    = 4,
  parameter int TOKEN_MAX = 8,
  parameter int MAX_OUT   = 4,
  parameter int WFW       = (NUM_WF > 1) ? $clog2(NUM_WF) : 1,
  parameter int PW        = $clog2(TOKEN_MAX + 1),
  parameter int CW        = $clog2(MAX_OUT + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_req,
  input  logic [WFW-1:0]       iss_wf,
  input  logic [1:0]           iss_kind,
  input  logic                 iss_idle,
  output logic                 iss_grant,
  input  logic                 cmp_valid,
  input  logic [WFW-1:0]       cmp_wf,
  input  logic [1:0]           cmp_kind,
  input  logic [PW-1:0]        tok_ret,
  output logic [PW-1:0]        pool_level,
  output logic [NUM_WF*CW-1:0] rd_cnt,
  output logic [NUM_WF*CW-1:0] wr_cnt,
  output logic                 err_pool_ovf,
  output logic                 err_underflow
);
  import wmc_pkg::*;

  localparam logic [CW:0] CEIL = (CW+1)'(MAX_OUT);

  op_kind_e    iss_k, cmp_k;
  logic [CW-1:0] rd_arr [NUM_WF];
  logic [CW-1:0] wr_arr [NUM_WF];
  logic [NUM_WF-1:0] uf_rd, uf_wr;
  logic [CW:0] busy;
  logic        wf_ok;
  logic        take_tok;
  logic        uf_any;
  logic        uerr_nxt;

  always_comb begin
    iss_k = op_kind_e'(iss_kind);
    cmp_k = op_kind_e'(cmp_kind);
    wf_ok = 32'(iss_wf) < NUM_WF;
    busy  = '0;
    if (wf_ok)
      busy = {1'b0, rd_arr[iss_wf]} + {1'b0, wr_arr[iss_wf]};
    iss_grant = iss_req && wf_ok && (pool_level != '0) && (busy < CEIL);
    take_tok  = iss_grant && !iss_idle;
  end

  wmc_token_pool #(.TOKEN_MAX(TOKEN_MAX), .PW(PW)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .acquire   (take_tok),
    .give_back (tok_ret),
    .level     (pool_level),
    .ovf_err   (err_pool_ovf)
  );

  for (genvar w = 0; w < NUM_WF; w++) begin : g_wave
    logic hit_iss, hit_cmp;
    assign hit_iss = iss_grant && (32'(iss_wf) == w);
    assign hit_cmp = cmp_valid && (32'(cmp_wf) == w);

    wmc_dir_counter #(.CW(CW)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (hit_iss && uses_read(iss_k)),
      .dec       (hit_cmp && uses_read(cmp_k)),
      .cnt       (rd_arr[w]),
      .underflow (uf_rd[w])
    );

    wmc_dir_counter #(.CW(CW)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (hit_iss && uses_write(iss_k)),
      .dec       (hit_cmp && uses_write(cmp_k)),
      .cnt       (wr_arr[w]),
      .underflow (uf_wr[w])
    );

    assign rd_cnt[w*CW +: CW] = rd_arr[w];
    assign wr_cnt[w*CW +: CW] = wr_arr[w];

    assert_combined_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, rd_arr[w]} + {1'b0, wr_arr[w]}) <= CEIL + 1'b1);
  end

  always_comb begin
    uf_any   = |{uf_rd, uf_wr};
    uerr_nxt = err_underflow | uf_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_underflow <= 1'b0;
    else if (uf_any)
      err_underflow <= uerr_nxt;
  end

  assert_grant_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_grant |-> iss_req);
  assert_uf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);
endmodule

// File: tb/sim_wf_mem_credit.sv
module sim_wf_mem_credit;
  localparam int NW = 4, TMAX = 8, MOUT = 4;
  localparam int WFW = 2, PW = 4, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iss_req = 0, iss_idle = 0, cmp_valid = 0;
  logic [WFW-1:0] iss_wf = '0, cmp_wf = '0;
  logic [1:0] iss_kind = '0, cmp_kind = '0;
  logic [PW-1:0] tok_ret = '0;
  logic iss_grant, err_pool_ovf, err_underflow;
  logic [PW-1:0] pool_level;
  logic [NW*CW-1:0] rd_cnt, wr_cnt;

  always #10 clk = ~clk;

  wf_mem_credit u0 (
    .clk(clk), .rst_n(rst_n), .iss_req(iss_req), .iss_wf(iss_wf),
    .iss_kind(iss_kind), .iss_idle(iss_idle), .iss_grant(iss_grant),
    .cmp_valid(cmp_valid), .cmp_wf(cmp_wf), .cmp_kind(cmp_kind),
    .tok_ret(tok_ret), .pool_level(pool_level), .rd_cnt(rd_cnt),
    .wr_cnt(wr_cnt), .err_pool_ovf(err_pool_ovf), .err_underflow(err_underflow)
  );

  int checks = 0, fails = 0;
  int m_pool, m_rd[NW], m_wr[NW];
  bit m_perr, m_uerr, done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit rd_kind(input int k); return k != 1; endfunction
  function automatic bit wr_kind(input int k); return k != 0; endfunction

  task automatic compare_state();
    chk("R4 pool level", int'(pool_level), m_pool);
    for (int w = 0; w < NW; w++) begin
      chk("R6 read counter", int'(rd_cnt[w*CW +: CW]), m_rd[w]);
      chk("R7 write counter", int'(wr_cnt[w*CW +: CW]), m_wr[w]);
    end
    chk("R9 pool error", int'(err_pool_ovf), int'(m_perr));
    chk("R10 underflow error", int'(err_underflow), int'(m_uerr));
  endtask

  // Called at a falling edge; leaves at the next falling edge.
  task automatic step(input bit req, input int wf, input int kind, input bit idle,
                      input bit cv, input int cwf, input int ck, input int ret);
    bit g;
    iss_req = req; iss_wf = WFW'(wf); iss_kind = 2'(kind); iss_idle = idle;
    cmp_valid = cv; cmp_wf = WFW'(cwf); cmp_kind = 2'(ck); tok_ret = PW'(ret);
    #2;
    g = req && (m_pool >= 1) && (m_rd[wf] + m_wr[wf] < MOUT);
    chk("R2 R3 grant", int'(iss_grant), int'(g));
    @(posedge clk);
    begin
      int np = m_pool - ((g && !idle) ? 1 : 0) + ret;
      if (np > TMAX) begin m_perr = 1; np = TMAX; end
      m_pool = np;
    end
    for (int w = 0; w < NW; w++) begin
      bit ir = g && wf == w && rd_kind(kind), dr = cv && cwf == w && rd_kind(ck);
      bit iw = g && wf == w && wr_kind(kind), dw = cv && cwf == w && wr_kind(ck);
      if (dr && !ir && m_rd[w] == 0) m_uerr = 1; else m_rd[w] += int'(ir) - int'(dr);
      if (dw && !iw && m_wr[w] == 0) m_uerr = 1; else m_wr[w] += int'(iw) - int'(dw);
    end
    #2;
    compare_state();
    @(negedge clk);
    iss_req = 0; cmp_valid = 0; tok_ret = '0; iss_idle = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    m_pool = TMAX; m_perr = 0; m_uerr = 0;
    for (int w = 0; w < NW; w++) begin m_rd[w] = 0; m_wr[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pool after reset", int'(pool_level), TMAX);
    chk("R1 read counters after reset", int'(rd_cnt), 0);
    chk("R1 write counters after reset", int'(wr_cnt), 0);
    chk("R1 flags after reset", int'({err_pool_ovf, err_underflow}), 0);

    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 loads fill reads", int'(rd_cnt[0 +: CW]), 4);
    step(1, 0, 0, 0, 0, 0, 0, 0);                 // R2 ceiling reached
    step(1, 1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0, 0);
    step(1, 2, 2, 0, 0, 0, 0, 0);
    chk("R6 atomic charges write", int'(wr_cnt[2*CW +: CW]), 1);
    step(1, 3, 3, 0, 0, 0, 0, 0);
    chk("R4 pool drained", int'(pool_level), 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);                 // R2 empty pool denies
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 1, 0, 0, 0, 0, 0, 2);                 // R8 acquire plus return
    chk("R8 acquire and return together", int'(pool_level), 2);
    step(1, 2, 1, 1, 0, 0, 0, 0);                 // R5 idle lanes
    chk("R5 idle grant keeps pool", int'(pool_level), 2);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 load completion", int'(rd_cnt[0 +: CW]), 3);
    step(0, 0, 0, 0, 1, 2, 2, 0);
    step(0, 0, 0, 0, 1, 3, 3, 0);
    chk("R7 sync completion clears both", int'({rd_cnt[3*CW +: CW], wr_cnt[3*CW +: CW]}), 0);
    step(1, 0, 0, 0, 1, 0, 0, 0);                 // R11
    chk("R11 issue and completion cancel", int'(rd_cnt[0 +: CW]), 3);
    step(0, 0, 0, 0, 1, 0, 1, 0);                 // R10
    chk("R10 underflow flag", int'(err_underflow), 1);
    step(0, 0, 0, 0, 0, 0, 0, 15);                // R9
    chk("R9 overfill flag", int'(err_pool_ovf), 1);
    chk("R9 pool clamped", int'(pool_level), TMAX);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_pool = TMAX; m_perr = 0; m_uerr = 0;
    for (int w = 0; w < NW; w++) begin m_rd[w] = 0; m_wr[w] = 0; end
    for (int i = 0; i < 400; i++) begin
      int cw, ck;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cw = int'(lf[9:8]); ck = int'(lf[11:10]);
      // complete only what is outstanding so the run stays meaningful
      step(lf[0], int'(lf[2:1]), int'(lf[4:3]), lf[5] & lf[6],
           lf[7] && (rd_kind(ck) ? m_rd[cw] > 0 : 1) && (wr_kind(ck) ? m_wr[cw] > 0 : 1),
           cw, ck, (lf[12] & lf[13]) ? 1 : 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule